// File: doc/BRIEF.md
# Setup-Driven Vertex Memory Read Prefetcher

The block sits between a shader processor and a small local vertex memory of 256 32-bit words. The processor pushes words into a four-entry write queue. A sideband flag marks each word as either plain data or a setup command. Words leave the queue one per cycle. A data word is stored at the current write address. A setup word replaces the active read or write configuration at the moment it leaves the queue.

Once a read configuration is active, a fill engine fetches consecutive words into a four-entry read queue on its own. The processor then pops them. The engine stops when the programmed count runs out, and it waits while the read queue is full. A later read setup cuts short any burst that is still pending. Because setups travel in order with data, software must drain one read burst before it queues the next.

Top module: `vtx_prefetch`

## Requirements
- R1: The write queue holds 4 entries of {setup flag, 32-bit word}. `push_ready` is high out of reset and low only while the queue is full. One entry leaves the queue per cycle whenever it is non-empty.
- R2: The read queue holds 4 words. `pop_ready` is high exactly when it is non-empty, and `pop_data` shows its oldest word. A pop happens on a clock edge where `pop_valid` and `pop_ready` are both high.
- R3: A setup takes effect only when it leaves the write queue. Suppose a read setup is accepted at edge k into an empty queue. It becomes active at edge k+1, and its first word is poppable after edge k+2. `pop_ready` stays low after edges k and k+1.
- R4: The fill engine fetches without any pop request. It stalls while the read queue is full, and it loses no words.
- R5: A read setup has bit 31 = 0 and bits 15:8 = 0x1A. Bits 7:0 give the start address and bits 23:20 give the count, where 0 means 16. Exactly that many words are delivered from consecutive addresses, and the address wraps modulo 256.
- R6: Suppose a new read setup becomes active while the previous burst still has unfetched words. Those words are abandoned, and words already in the read queue are kept. Filling then follows the new setup.
- R7: A write setup has bit 31 = 1 and bits 15:8 = 0x1A, with bits 7:0 giving the start address. Each data word that leaves the queue afterwards is written at the current write address, which then increments.
- R8: After reset no setup is active. No words are fetched, and `pop_ready` stays low. Data words that leave the queue before any write setup are dropped, and memory contents are not cleared by reset.
- R9: A setup word whose bits 15:8 are not 0x1A is ignored. The previously active read and write configurations stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request |
| push_ready | output | 1 | Write queue can accept |
| push_setup | input | 1 | Pushed word is a setup command |
| push_data | input | 32 | Pushed word |
| pop_valid | input | 1 | Pop request |
| pop_ready | output | 1 | Read queue holds a word |
| pop_data | output | 32 | Oldest word of the read queue |

## Verification
The path from an accepted read setup to its first word has a fixed length. The word enters the write queue at edge k, becomes active at k+1 and is fetched at k+2. The bench therefore samples `pop_ready` on the falling edge after each of those three edges. Burst reads wait on `pop_ready` with a bounded poll at falling edges, then pop on the next rising edge. A few idle cycles are allowed after a burst, so the count being exact (R5) and the abandoned tail (R6) both appear as `pop_ready` staying low. Whether a word was dropped or ignored is judged by reading the affected addresses back through a read setup.

// File: rtl/vtx_pkg.sv
package vtx_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int MAX_BURST = 16;
  localparam int CNT_W     = $clog2(MAX_BURST + 1);
  localparam logic [7:0] SETUP_TAG = 8'h1A;

  // setup word: bit31 kind (1=write), 23:20 count (0 => 16), 15:8 tag, 7:0 addr
  function automatic logic cfg_supported(input logic [DATA_W-1:0] w);
    return w[15:8] == SETUP_TAG;
  endfunction

  function automatic logic cfg_is_write(input logic [DATA_W-1:0] w);
    return w[31];
  endfunction

  function automatic logic [ADDR_W-1:0] cfg_addr(input logic [DATA_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] cfg_count(input logic [DATA_W-1:0] w);
    return (w[23:20] == 4'd0) ? CNT_W'(MAX_BURST) : CNT_W'(w[23:20]);
  endfunction

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/vtx_fifo.sv
module vtx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rd_ptr];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        store[wr_ptr] <= push_data;
        wr_ptr        <= wrap_inc(wr_ptr);
      end
      if (do_pop) rd_ptr <= wrap_inc(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R1 / R2: occupancy never exceeds the queue depth
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/vtx_store.sv
module vtx_store #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/vtx_fill.sv
module vtx_fill
  import vtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [ADDR_W-1:0] apply_addr,
  input  logic [CNT_W-1:0]  apply_count,
  input  logic              dst_full,
  output logic              fetch,
  output logic [ADDR_W-1:0] fetch_addr
);
  logic [ADDR_W-1:0] rd_addr;
  logic [CNT_W-1:0]  rd_left;

  assign fetch      = (rd_left != '0) && !dst_full;
  assign fetch_addr = rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_addr <= '0;
      rd_left <= '0;
    end else if (apply) begin
      rd_addr <= apply_addr;     // a new setup discards any pending tail
      rd_left <= apply_count;
    end else if (fetch) begin
      rd_addr <= addr_next(rd_addr);
      rd_left <= rd_left - 1'b1;
    end
  end

  // R5: consecutive fetches of one burst step the address by one
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fetch) && !$past(apply) |-> rd_addr == addr_next($past(rd_addr)));

  // R5: a burst never exceeds the maximum length
  p_left_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_left <= CNT_W'(MAX_BURST));

  // R6: an applied setup replaces the remaining count outright
  p_replace_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(apply) |-> rd_left == $past(apply_count));
endmodule

// File: rtl/vtx_prefetch.sv
module vtx_prefetch
  import vtx_pkg::*;
#(
  parameter int WQ_DEPTH = 4,
  parameter int RQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic              push_setup,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_valid,
  output logic              pop_ready,
  output logic [DATA_W-1:0] pop_data
);
  logic              wq_full, wq_empty, drain;
  logic [DATA_W:0]   wq_head;
  logic              head_setup;
  logic [DATA_W-1:0] head_word;
  logic              rd_apply, wr_apply, data_wr;
  logic              rq_full, rq_empty, fetch;
  logic [ADDR_W-1:0] fetch_addr;
  logic [DATA_W-1:0] fetch_word;
  logic              wr_valid, rd_seen;
  logic [ADDR_W-1:0] wr_addr;

  assign push_ready = !wq_full;
  assign drain      = !wq_empty;
  assign head_setup = wq_head[DATA_W];
  assign head_word  = wq_head[DATA_W-1:0];

  vtx_fifo #(.W(DATA_W + 1), .DEPTH(WQ_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n),
    .push(push_valid), .push_data({push_setup, push_data}),
    .pop(drain), .head(wq_head), .full(wq_full), .empty(wq_empty)
  );

  // named drain events
  assign rd_apply = drain && head_setup && cfg_supported(head_word) && !cfg_is_write(head_word);
  assign wr_apply = drain && head_setup && cfg_supported(head_word) &&  cfg_is_write(head_word);
  assign data_wr  = drain && !head_setup && wr_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      rd_seen  <= 1'b0;
    end else begin
      if (wr_apply) begin
        wr_valid <= 1'b1;
        wr_addr  <= cfg_addr(head_word);
      end else if (data_wr) begin
        wr_addr  <= addr_next(wr_addr);
      end
      if (rd_apply) rd_seen <= 1'b1;
    end
  end

  vtx_store #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .wr_en(data_wr), .wr_addr(wr_addr), .wr_data(head_word),
    .rd_addr(fetch_addr), .rd_data(fetch_word)
  );

  vtx_fill u_fill (
    .clk(clk), .rst_n(rst_n),
    .apply(rd_apply), .apply_addr(cfg_addr(head_word)), .apply_count(cfg_count(head_word)),
    .dst_full(rq_full), .fetch(fetch), .fetch_addr(fetch_addr)
  );

  vtx_fifo #(.W(DATA_W), .DEPTH(RQ_DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n),
    .push(fetch), .push_data(fetch_word),
    .pop(pop_valid), .head(pop_data), .full(rq_full), .empty(rq_empty)
  );

  assign pop_ready = !rq_empty;

  // R8: the fill engine stays idle until a read setup has drained
  p_quiet_before_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_seen |-> !fetch);

  // R4: a fetch never targets a full read queue
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> !rq_full);

  // R7: a write configuration follows an applied write setup
  p_wr_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_apply) |-> wr_valid && wr_addr == cfg_addr($past(head_word)));
endmodule

// File: tb/vtx_prefetch_test.sv
module vtx_prefetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0, push_setup = 1'b0, pop_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic        push_ready, pop_ready;
  logic [31:0] pop_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  vtx_prefetch uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_setup(push_setup), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data)
  );

  // {addr[7:0], count field[3:0]}
  localparam logic [11:0] VEC [0:4] = '{12'h001, 12'h050, 12'hFA8, 12'h804, 12'h11F};

  function automatic logic [31:0] exp_word(input int i);
    logic [7:0] a;
    a = 8'(i);
    return {16'hC0DE, a, ~a};
  endfunction

  function automatic logic [31:0] rsetup(input logic [7:0] a, input logic [3:0] c);
    return {1'b0, 7'd0, c, 4'd0, 8'h1A, a};
  endfunction

  function automatic logic [31:0] wsetup(input logic [7:0] a);
    return {1'b1, 7'd0, 4'd0, 4'd0, 8'h1A, a};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic s, input logic [31:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_setup = s; push_data = d;
    @(posedge clk);
    #1 push_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_word(output logic [31:0] d, output bit ok);
    ok = 0; d = '0;
    for (int t = 0; t < 20 && !ok; t++) begin
      @(negedge clk);
      if (pop_ready) begin
        d = pop_data; ok = 1; pop_valid = 1'b1;
        @(posedge clk);
        #1 pop_valid = 1'b0;
      end
    end
  endtask

  task automatic read_burst(input string tag, input int a, input int n);
    logic [31:0] got;
    bit ok;
    for (int i = 0; i < n; i++) begin
      pop_word(got, ok);
      if (!ok) got = 32'hDEAD_0000;
      check(tag, got, exp_word(a + i));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    bit ok;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R8 / R1: reset state
    check("R8 pop_ready after reset", {31'd0, pop_ready}, 32'd0);
    check("R1 push_ready after reset", {31'd0, push_ready}, 32'd1);
    idle(8);
    check("R8 no fetch without setup", {31'd0, pop_ready}, 32'd0);

    // R7: fill the whole memory, address wraps after 255
    push(1'b1, wsetup(8'd0));
    for (int i = 0; i < 256; i++) push(1'b0, exp_word(i));
    idle(4);

    // R3: latency of a read setup
    push(1'b1, rsetup(8'd7, 4'd1));
    @(negedge clk) check("R3 ready after entry edge", {31'd0, pop_ready}, 32'd0);
    @(negedge clk) check("R3 ready after apply edge", {31'd0, pop_ready}, 32'd0);
    @(negedge clk) check("R3 ready after fetch edge", {31'd0, pop_ready}, 32'd1);
    read_burst("R3 R7 first word", 7, 1);

    // R5: vector table of bursts
    for (int v = 0; v < 5; v++) begin
      int a, n;
      a = int'(VEC[v][11:4]);
      n = (VEC[v][3:0] == 4'd0) ? 16 : int'(VEC[v][3:0]);
      push(1'b1, rsetup(VEC[v][11:4], VEC[v][3:0]));
      read_burst("R5 burst data", a, n);
      idle(6);
      check("R5 exact count", {31'd0, pop_ready}, 32'd0);
    end

    // R4 / R6: stall while full, then abandon the tail
    push(1'b1, rsetup(8'd40, 4'd0));
    idle(10);
    push(1'b1, rsetup(8'd100, 4'd2));
    idle(5);
    read_burst("R4 R6 kept words", 40, 4);
    read_burst("R6 new burst", 100, 2);
    idle(6);
    check("R6 tail abandoned", {31'd0, pop_ready}, 32'd0);

    // R9: unsupported read setup ignored
    push(1'b1, {1'b0, 7'd0, 4'd2, 4'd0, 8'h1B, 8'd3});
    idle(8);
    check("R9 bad read setup ignored", {31'd0, pop_ready}, 32'd0);

    // R9 / R7: unsupported write setup keeps old write address
    push(1'b1, wsetup(8'd30));
    push(1'b1, {1'b1, 7'd0, 8'd0, 8'h00, 8'd60});
    push(1'b0, 32'h1234_5678);
    push(1'b1, rsetup(8'd30, 4'd1));
    pop_word(got, ok);
    check("R7 R9 write at kept address", got, 32'h1234_5678);
    push(1'b1, rsetup(8'd60, 4'd1));
    read_burst("R9 bad address untouched", 60, 1);

    // R8: data before any write setup is dropped
    @(negedge clk) rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    check("R8 pop_ready after second reset", {31'd0, pop_ready}, 32'd0);
    push(1'b0, 32'h0BAD_F00D);
    idle(4);
    push(1'b1, rsetup(8'd0, 4'd1));
    read_burst("R8 dropped data", 0, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule